// File: doc/BRIEF.md
# Edge-Triggered Phase-Frequency Detector

This block compares a reference input against a feedback input, typically a divided oscillator clock, and tells a charge-pump loop which way to steer. Both inputs are asynchronous square waves. They are brought into a fast system clock domain through a synchronizer and reduced to single-cycle rising-edge events. Only those events move the detector, so the high time of either input has no effect on the result.

A reference edge arms an "up" request and a feedback edge arms a "down" request. When both are armed they cancel together on the next system clock. The net request is presented as two mutually exclusive enables and as one three-state pin: the pin pulls high to speed the oscillator up, pulls low to slow it down, and floats otherwise. With equal frequencies, each drive pulse lasts exactly as many system clocks as the edges are apart. A plain exclusive-OR of the synchronized inputs is also provided for loops that prefer a mixer-type comparator.

A lock monitor watches pulse lengths against a run-time threshold and raises a locked flag after a parameterized number of consecutive quiet reference cycles. An inhibit input idles the whole detector. The block has no streaming data path, so every pin is a plain control or status level with no valid/ready handshake.

Top module: `edge_phase_detector`

## Requirements
- R1: Only rising edges of `ref_in` and `fb_in` act. A rising input seen at clock edge A appears on the drive enable after edge A+2, which is three edges later, and the input high time does not change any pulse length.
- R2: At equal frequencies with the reference edge d clocks ahead of the feedback edge, `pump_up` gives one pulse of exactly d cycles per period.
- R3: At equal frequencies with the feedback edge d clocks ahead of the reference edge, `pump_dn` gives one pulse of exactly d cycles per period.
- R4: Coincident edges give no drive pulse. `pump_up` and `pump_dn` are never both 1. When both requests are armed, both clear on the next clock.
- R5: When the reference frequency is higher than the feedback frequency, `pump_up` is asserted for more than half the time after settling and `pump_dn` stays 0.
- R6: When the reference frequency is lower than the feedback frequency, `pump_dn` is asserted for more than half the time after settling and `pump_up` stays 0.
- R7: `pump_pin` is 1 while `pump_up` is 1, is 0 while `pump_dn` is 1, and is high-impedance while both are 0.
- R8: `phase_xor` equals the synchronized reference XOR the synchronized feedback, two clocks behind the pins. It is 0 while `inhibit` is 1.
- R9: While `inhibit` is 1, both enables are 0 in the same cycle and the pin floats. Both requests, the lock streak and `locked` are cleared, so no request armed before inhibit survives its release.
- R10: `locked` rises on the LOCK_N-th consecutive reference edge during which no drive pulse has reached `lock_limit` cycles.
- R11: A drive pulse that reaches `lock_limit` cycles clears `locked` and restarts the streak. A pulse one cycle shorter than that does not.
- R12: Synchronous reset `rst` clears both requests, the synchronizer, the lock streak and `locked`. Once `rst` is released, no pulse appears without a new input edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous reset, active high |
| inhibit | input | 1 | 1 idles the detector and floats the output; 0 runs it |
| ref_in | input | 1 | Reference square wave, asynchronous |
| fb_in | input | 1 | Feedback square wave, asynchronous |
| lock_limit | input | CNT_W | Pulse length in clocks at or above which lock is refused |
| pump_up | output | 1 | Enable for driving the pin high (speed up) |
| pump_dn | output | 1 | Enable for driving the pin low (slow down) |
| pump_pin | output | 1 | Three-state control node: 1, 0 or Z |
| phase_xor | output | 1 | Exclusive-OR phase comparator output |
| locked | output | 1 | Loop judged in lock |

## Verification
An armed request that fails to clear, or clears one cycle late, shows on the enables within one reference period. It appears either as a pulse one cycle longer than the edge spacing or as a stray drive in the wrong direction on the next feedback edge. A synchronizer or edge detector that is one stage off moves the start of every pulse by a cycle, and the fixed A+2 latency exposes it at the first edge. A lock streak that is counted wrongly moves the rise of `locked` by one reference edge. A missed long-pulse comparison leaves `locked` high after the first pulse of `lock_limit` cycles.

// File: rtl/epd_pkg.sv
package epd_pkg;
  typedef enum logic [1:0] {
    DRV_FLOAT = 2'b00,
    DRV_HIGH  = 2'b01,
    DRV_LOW   = 2'b10
  } drv_e;

  localparam int IDX_REF = 0;
  localparam int IDX_FB  = 1;
  localparam int N_INPUTS = 2;
endpackage

// File: rtl/epd_edge_sync.sv
module epd_edge_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] rise
);
  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] chain_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
      prev_q <= '0;
    end else begin
      chain_q[0] <= din;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      prev_q <= chain_q[LAST];
    end
  end

  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_bit
      assign level[g] = chain_q[LAST][g];
      assign rise[g]  = chain_q[LAST][g] & ~prev_q[g];
    end
  endgenerate
endmodule

// File: rtl/epd_flag_core.sv
module epd_flag_core
  import epd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic inhibit,
  input  logic ref_rise,
  input  logic fb_rise,
  output drv_e drive
);
  logic up_q, dn_q;
  logic both;

  assign both = up_q & dn_q;

  always_ff @(posedge clk) begin
    if (rst || inhibit) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else if (both) begin
      up_q <= ref_rise;
      dn_q <= fb_rise;
    end else begin
      up_q <= up_q | ref_rise;
      dn_q <= dn_q | fb_rise;
    end
  end

  always_comb begin
    drive = DRV_FLOAT;
    if (!inhibit) begin
      if (up_q && !dn_q)      drive = DRV_HIGH;
      else if (dn_q && !up_q) drive = DRV_LOW;
    end
  end
endmodule

// File: rtl/epd_lock_mon.sv
module epd_lock_mon #(
  parameter int CNT_W  = 8,
  parameter int LOCK_N = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inhibit,
  input  logic             active,
  input  logic             ref_rise,
  input  logic [CNT_W-1:0] lock_limit,
  output logic             locked
);
  localparam int STREAK_W = (LOCK_N > 1) ? $clog2(LOCK_N) : 1;
  localparam logic [STREAK_W-1:0] STREAK_TOP = STREAK_W'(LOCK_N - 1);

  logic [CNT_W-1:0]    run_q;
  logic [CNT_W:0]      run_next;
  logic [STREAK_W-1:0] streak_q;
  logic                long_pulse;

  assign run_next   = {1'b0, run_q} + 1'b1;
  assign long_pulse = active && (run_next >= {1'b0, lock_limit});

  always_ff @(posedge clk) begin
    if (rst || inhibit) begin
      run_q    <= '0;
      streak_q <= '0;
      locked   <= 1'b0;
    end else begin
      if (!active)          run_q <= '0;
      else if (~&run_q)     run_q <= run_next[CNT_W-1:0];

      if (long_pulse) begin
        streak_q <= '0;
        locked   <= 1'b0;
      end else if (ref_rise) begin
        if (streak_q == STREAK_TOP) locked <= 1'b1;
        else                        streak_q <= streak_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/edge_phase_detector.sv
module edge_phase_detector
  import epd_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int LOCK_N      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inhibit,
  input  logic             ref_in,
  input  logic             fb_in,
  input  logic [CNT_W-1:0] lock_limit,
  output logic             pump_up,
  output logic             pump_dn,
  output logic             pump_pin,
  output logic             phase_xor,
  output logic             locked
);
  logic [N_INPUTS-1:0] raw_in, lvl, rise;
  drv_e                drive;

  assign raw_in[IDX_REF] = ref_in;
  assign raw_in[IDX_FB]  = fb_in;

  epd_edge_sync #(.WIDTH(N_INPUTS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .din   (raw_in),
    .level (lvl),
    .rise  (rise)
  );

  epd_flag_core u_core (
    .clk      (clk),
    .rst      (rst),
    .inhibit  (inhibit),
    .ref_rise (rise[IDX_REF]),
    .fb_rise  (rise[IDX_FB]),
    .drive    (drive)
  );

  assign pump_up = (drive == DRV_HIGH);
  assign pump_dn = (drive == DRV_LOW);

  epd_lock_mon #(.CNT_W(CNT_W), .LOCK_N(LOCK_N)) u_lock (
    .clk        (clk),
    .rst        (rst),
    .inhibit    (inhibit),
    .active     (drive != DRV_FLOAT),
    .ref_rise   (rise[IDX_REF]),
    .lock_limit (lock_limit),
    .locked     (locked)
  );

  assign pump_pin  = pump_up ? 1'b1 : (pump_dn ? 1'b0 : 1'bz);
  assign phase_xor = ~inhibit & (lvl[IDX_REF] ^ lvl[IDX_FB]);
endmodule

// File: rtl/epd_checker.sv
module epd_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             inhibit,
  input logic             ref_in,
  input logic             fb_in,
  input logic [CNT_W-1:0] lock_limit,
  input logic             pump_up,
  input logic             pump_dn,
  input logic             locked
);
  logic [CNT_W-1:0] act_run;
  logic [CNT_W:0]   run_plus;

  assign run_plus = {1'b0, act_run} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || !(pump_up || pump_dn)) act_run <= '0;
    else if (~&act_run)               act_run <= run_plus[CNT_W-1:0];
  end

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pump_up, pump_dn})); // R4

  AST_UP_FROM_REF_EDGE: assert property (@(posedge clk) disable iff (rst)
    $rose(pump_up) |-> ($past(ref_in, 3) && !$past(ref_in, 4))); // R1

  AST_DN_FROM_FB_EDGE: assert property (@(posedge clk) disable iff (rst)
    $rose(pump_dn) |-> ($past(fb_in, 3) && !$past(fb_in, 4))); // R1

  AST_INHIBIT_CLEARS_REQ: assert property (@(posedge clk) disable iff (rst)
    $past(inhibit) |-> (!pump_up && !pump_dn)); // R9

  AST_INHIBIT_DROPS_LOCK: assert property (@(posedge clk) disable iff (rst)
    inhibit |=> !locked); // R9

  AST_LONG_PULSE_UNLOCKS: assert property (@(posedge clk) disable iff (rst)
    ((pump_up || pump_dn) && (run_plus >= {1'b0, lock_limit})) |=> !locked); // R11

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!pump_up && !pump_dn && !locked)); // R12
endmodule

bind edge_phase_detector epd_checker #(.CNT_W(CNT_W)) u_epd_chk (
  .clk        (clk),
  .rst        (rst),
  .inhibit    (inhibit),
  .ref_in     (ref_in),
  .fb_in      (fb_in),
  .lock_limit (lock_limit),
  .pump_up    (pump_up),
  .pump_dn    (pump_dn),
  .locked     (locked)
);

// File: tb/edge_phase_detector_test.sv
`timescale 1ns/1ps
module edge_phase_detector_test;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inhibit = 1'b0;
  logic ref_in = 1'b0;
  logic fb_in = 1'b0;
  logic [CNT_W-1:0] lock_limit = 8'd4;
  wire pump_up, pump_dn, pump_pin, phase_xor, locked;

  edge_phase_detector #(.CNT_W(CNT_W), .LOCK_N(4), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .inhibit(inhibit), .ref_in(ref_in), .fb_in(fb_in),
    .lock_limit(lock_limit), .pump_up(pump_up), .pump_dn(pump_dn),
    .pump_pin(pump_pin), .phase_xor(phase_xor), .locked(locked)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit sb_on = 1'b0;
  bit done = 1'b0;

  typedef struct { bit up; int len; } pulse_t;
  pulse_t exp_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: one period per loop, edges at given offsets, pushes expected pulse.
  task automatic run_pair(input int period, input int ref_off, input int fb_off,
                          input int ref_hi, input int fb_hi, input int n);
    for (int c = 0; c < n; c++) begin
      if (sb_on && ref_off != fb_off) begin
        pulse_t p;
        p.up  = (ref_off < fb_off);
        p.len = p.up ? fb_off - ref_off : ref_off - fb_off;
        exp_q.push_back(p);
      end
      for (int t = 0; t < period; t++) begin
        @(negedge clk);
        ref_in = (t >= ref_off) && (t < ref_off + ref_hi);
        fb_in  = (t >= fb_off) && (t < fb_off + fb_hi);
      end
    end
  endtask

  // Monitor: measures drive pulses and compares them with the scoreboard.
  int  run_len = 0;
  bit  run_up = 1'b0;
  bit  pin_ok = 1'b1;
  always @(negedge clk) begin
    if (sb_on) begin
      if (pump_up || pump_dn) begin
        if (run_len == 0) run_up = pump_up;
        run_len++;
        if ((pump_up && pump_pin !== 1'b1) || (pump_dn && pump_pin !== 1'b0)) pin_ok = 1'b0;
      end else if (run_len > 0) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4", "unexpected drive pulse length", run_len, 0);
        end else begin
          pulse_t e;
          e = exp_q.pop_front();
          check(run_up == e.up && run_len == e.len, e.up ? "R2" : "R3",
                "signed pulse length (+up/-dn)",
                run_up ? run_len : -run_len, e.up ? e.len : -e.len);
          check(pin_ok, "R7", "pin level matched enable during pulse", pin_ok, 1);
        end
        run_len = 0;
        pin_ok  = 1'b1;
      end
    end
  end

  task automatic drain(input string req);
    step(10);
    check(exp_q.size() == 0, req, "expected pulses never seen", exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic do_reset();
    ref_in = 1'b0; fb_in = 1'b0; inhibit = 1'b0;
    rst = 1'b1; step(3); rst = 1'b0; step(3);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int up_c, dn_c;
    // Reset state (R12)
    step(3);
    check(!pump_up && !pump_dn, "R12", "enables during reset", {pump_up, pump_dn}, 0);
    check(!locked, "R12", "locked during reset", locked, 0);
    check(!phase_xor, "R8", "xor during reset", phase_xor, 0);
    rst = 1'b0; step(3);

    // Equal frequency, scoreboard mode (R2, R3, R1 duty, R4 coincidence)
    sb_on = 1'b1;
    run_pair(20, 2, 5, 6, 6, 3);   // R2 d=3
    run_pair(20, 2, 9, 6, 6, 2);   // R2 d=7
    run_pair(20, 8, 3, 6, 6, 3);   // R3 d=5
    run_pair(20, 2, 6, 1, 12, 2);  // R1 narrow ref high time
    run_pair(20, 2, 6, 14, 2, 2);  // R1 wide ref high time
    run_pair(20, 4, 4, 6, 6, 3);   // R4 coincident edges
    drain("R4");

    // Lock detection (R10, R11)
    sb_on = 1'b0; do_reset(); sb_on = 1'b1;
    run_pair(16, 2, 3, 4, 4, 3);
    check(!locked, "R10", "locked after LOCK_N-1 quiet edges", locked, 0);
    run_pair(16, 2, 3, 4, 4, 1);
    check(locked, "R10", "locked after LOCK_N quiet edges", locked, 1);
    run_pair(16, 2, 5, 4, 4, 1);   // pulse 3 < limit 4
    check(locked, "R11", "locked kept for pulse limit-1", locked, 1);
    run_pair(16, 6, 2, 4, 4, 1);   // pulse 4 == limit
    check(!locked, "R11", "locked cleared by pulse at limit", locked, 0);
    drain("R11");
    sb_on = 1'b0;

    // Reference faster (R5)
    do_reset();
    up_c = 0; dn_c = 0;
    for (int t = 0; t < 700; t++) begin
      @(negedge clk);
      if (t >= 100) begin up_c += pump_up; dn_c += pump_dn; end
      ref_in = (t % 10) < 5;
      fb_in  = (t % 14) < 7;
    end
    check(up_c > 300, "R5", "up cycles in 600", up_c, 301);
    check(dn_c == 0, "R5", "down cycles in 600", dn_c, 0);

    // Reference slower (R6)
    do_reset();
    up_c = 0; dn_c = 0;
    for (int t = 0; t < 700; t++) begin
      @(negedge clk);
      if (t >= 100) begin up_c += pump_up; dn_c += pump_dn; end
      ref_in = (t % 14) < 7;
      fb_in  = (t % 10) < 5;
    end
    check(dn_c > 300, "R6", "down cycles in 600", dn_c, 301);
    check(up_c == 0, "R6", "up cycles in 600", up_c, 0);

    // XOR comparator (R8)
    do_reset();
    ref_in = 1'b1; step(3);
    check(phase_xor, "R8", "xor ref=1 fb=0", phase_xor, 1);
    fb_in = 1'b1; step(3);
    check(!phase_xor, "R8", "xor ref=1 fb=1", phase_xor, 0);
    ref_in = 1'b0; step(3);
    check(phase_xor, "R8", "xor ref=0 fb=1", phase_xor, 1);

    // Latency and inhibit (R1, R9, R7)
    do_reset();
    ref_in = 1'b1; step(2);
    check(!pump_up, "R1", "up two edges after input rise", pump_up, 0);
    step(1);
    check(pump_up, "R1", "up three edges after input rise", pump_up, 1);
    check(pump_pin === 1'b1, "R7", "pin high while up", pump_pin === 1'b1, 1);
    inhibit = 1'b1; #1;
    check(!pump_up && !pump_dn, "R9", "enables under inhibit", {pump_up, pump_dn}, 0);
    check(!phase_xor, "R8", "xor gated by inhibit", phase_xor, 0);
    step(3); inhibit = 1'b0; step(3);
    check(!pump_up, "R9", "up request cleared by inhibit", pump_up, 0);
    fb_in = 1'b1; step(4);
    check(pump_dn, "R9", "feedback edge drives low with no stale up", pump_dn, 1);
    check(pump_pin === 1'b0, "R7", "pin low while down", pump_pin === 1'b0, 1);
    ref_in = 1'b0; step(2); ref_in = 1'b1; step(5);
    check(!pump_up && !pump_dn, "R4", "requests cancel", {pump_up, pump_dn}, 0);

    // Reset mid-pulse (R12)
    do_reset();
    ref_in = 1'b1; step(5);
    check(pump_up, "R2", "up pulse running before reset", pump_up, 1);
    ref_in = 1'b0; rst = 1'b1; step(2);
    check(!pump_up && !pump_dn && !locked, "R12", "state during reset",
          {pump_up, pump_dn, locked}, 0);
    rst = 1'b0; step(5);
    check(!pump_up && !pump_dn, "R12", "no pulse after reset", {pump_up, pump_dn}, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule